// File: doc/BRIEF.md
# Memory Concurrency Activity Monitor

This block is a passive observer that sits next to one level of a cache. It does not change cache behaviour. Every cycle it sees how many hit accesses the cache is servicing, when a new access starts, and when miss-tracking entries are allocated and retired. It keeps its own record of which miss entries are outstanding. From these inputs it accumulates nine saturating counters. Software reads the counters and derives the figures it needs, such as accesses per memory-active cycle and its reciprocal (the concurrent average access time), hit concurrency, miss-level parallelism, the share of miss cycles that are pure, and the share of misses that are pure.

A cycle counts as memory-active when any hit or miss is in progress, and it counts once however many accesses overlap in it. A pure-miss cycle is a cycle with at least one outstanding miss and no hit being serviced. A miss is marked pure if any cycle of its lifetime was a pure-miss cycle while counting was enabled. The mark is held as a sticky flag per tracking entry and is counted when that entry retires. An enable input opens and closes the sampling window. A synchronous clear restarts the window.

Top module: `memmon_top`

## Requirements
- R1: Counter address 0 (accesses) increases by one in each enabled cycle with `accessStart` high.
- R2: Counter address 1 (active cycles) increases by exactly one in each enabled cycle in which `hitActive` is nonzero or at least one miss entry is outstanding. It does not change in any other cycle.
- R3: Counter address 2 (hit cycles) increases by one in each enabled cycle with nonzero `hitActive`. Counter address 3 (hit sum) increases by the value of `hitActive` in each enabled cycle.
- R4: An entry is outstanding from the cycle after its accepted allocation up to and including the cycle in which it retires. In each enabled cycle, counter address 4 (miss cycles) increases by one if any entry is outstanding, and counter address 8 (occupancy sum) increases by the number of outstanding entries.
- R5: Counter address 5 (pure-miss cycles) increases by one in each enabled cycle with at least one outstanding entry and `hitActive` equal to zero.
- R6: Counter address 6 (misses) increases by one for each accepted retire. A retire that names an entry that is not outstanding is ignored. An allocate that names an entry that is already outstanding is ignored.
- R7: Counter address 7 (pure misses) increases by one when an accepted retire, in an enabled cycle, names an entry that saw at least one enabled pure-miss cycle. The retire cycle itself counts as one of those cycles.
- R8: While `enable` is low, no counter changes. Allocates and retires are still tracked, so occupancy is correct once `enable` returns high.
- R9: A cycle with `clear` high sets every counter to zero and drops every pure flag. Clear takes precedence over any count in that same cycle.
- R10: A counter that reaches all ones stays at all ones until it is cleared.
- R11: `rdData` shows, one cycle after `rdAddr` is presented, the value the addressed counter held before that clock edge. Addresses 9 to 15 read as zero. After reset, all counters and `rdData` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counting window open |
| clear | input | 1 | Synchronous clear of counters and pure flags |
| accessStart | input | 1 | An access starts this cycle |
| hitActive | input | HIT_W | Number of hit accesses being serviced this cycle |
| allocValid | input | 1 | A miss entry is allocated |
| allocId | input | ID_W | Index of the allocated entry |
| retireValid | input | 1 | A miss entry completes |
| retireId | input | ID_W | Index of the completed entry |
| rdAddr | input | ADDR_W | Counter select |
| rdData | output | CNT_W | Registered counter value |

## Verification
The hardest case to reach from the ports is the pure flag of a single miss entry. The flag is set only when that entry is outstanding, no hit is active, and counting is enabled. It must be dropped by a clear while the entry is still in flight, and it must count when purity first appears in the retire cycle itself. Directed sequences build each of these cases on its own: a miss that retires with a hit present, a miss whose only hit-free cycle is its retire cycle, and a flagged miss that lives through a clear. A long pseudo-random sweep then mixes overlapping allocates, retires, bogus ids, hit counts and enable gaps. In that sweep, every counter is compared against totals the bench computes arithmetically.

// File: rtl/memmon_pkg.sv
`timescale 1ns/1ps
package memmon_pkg;
  localparam int NUM_CNT = 9;
  localparam int INC_W   = 8;
  localparam int ADDR_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    CNT_ACCESS    = 4'd0,
    CNT_ACTIVE    = 4'd1,
    CNT_HIT_CYC   = 4'd2,
    CNT_HIT_SUM   = 4'd3,
    CNT_MISS_CYC  = 4'd4,
    CNT_PURE_CYC  = 4'd5,
    CNT_MISS      = 4'd6,
    CNT_PURE_MISS = 4'd7,
    CNT_OCC_SUM   = 4'd8
  } cntIdxE;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic                              clear;
    logic [NUM_CNT-1:0][INC_W-1:0]     incAmt;
  } strobeT;
endpackage

// File: rtl/memmon_ctrl.sv
`timescale 1ns/1ps
module memmon_ctrl
  import memmon_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int HIT_W   = 4,
  localparam int ID_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int OCC_W  = $clog2(ENTRIES + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            clear,
  input  logic            accessStart,
  input  logic [HIT_W-1:0] hitActive,
  input  logic            allocValid,
  input  logic [ID_W-1:0] allocId,
  input  logic            retireValid,
  input  logic [ID_W-1:0] retireId,
  output strobeT          strobes
);

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entPure;
  logic [OCC_W-1:0]   occCount;
  logic               hitAny, missAny, pureNow;
  logic               allocOk, retireOk, retirePure;

  always_comb begin
    occCount   = '0;
    allocOk    = 1'b0;
    retireOk   = 1'b0;
    retirePure = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      occCount = occCount + OCC_W'(entValid[i]);
      if (allocValid && allocId == ID_W'(i) && !entValid[i]) allocOk = 1'b1;
      if (retireValid && retireId == ID_W'(i) && entValid[i]) begin
        retireOk   = 1'b1;
        retirePure = entPure[i];
      end
    end
  end

  assign hitAny  = (hitActive != '0);
  assign missAny = (occCount != '0);
  assign pureNow = missAny && !hitAny;

  always_comb begin
    strobes       = '0;
    strobes.clear = clear;
    if (enable) begin
      strobes.incAmt[CNT_ACCESS]    = INC_W'(accessStart);
      strobes.incAmt[CNT_ACTIVE]    = INC_W'(hitAny || missAny);
      strobes.incAmt[CNT_HIT_CYC]   = INC_W'(hitAny);
      strobes.incAmt[CNT_HIT_SUM]   = INC_W'(hitActive);
      strobes.incAmt[CNT_MISS_CYC]  = INC_W'(missAny);
      strobes.incAmt[CNT_PURE_CYC]  = INC_W'(pureNow);
      strobes.incAmt[CNT_MISS]      = INC_W'(retireOk);
      strobes.incAmt[CNT_PURE_MISS] = INC_W'(retireOk && (retirePure || pureNow));
      strobes.incAmt[CNT_OCC_SUM]   = INC_W'(occCount);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
      entPure  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (retireOk && retireId == ID_W'(i))      entValid[i] <= 1'b0;
        else if (allocOk && allocId == ID_W'(i))   entValid[i] <= 1'b1;

        if (clear)                                 entPure[i] <= 1'b0;
        else if (allocOk && allocId == ID_W'(i))   entPure[i] <= 1'b0;
        else if (retireOk && retireId == ID_W'(i)) entPure[i] <= 1'b0;
        else if (enable && pureNow && entValid[i]) entPure[i] <= 1'b1;
      end
    end
  end

  // A pure flag only lives on an outstanding entry
  assert_pure_on_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (entPure & ~entValid) == '0);

  // A pure miss is always also a miss
  assert_pure_miss_is_miss_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incAmt[CNT_PURE_MISS] != '0 |-> strobes.incAmt[CNT_MISS] != '0);

  // Nothing is counted outside the window
  assert_idle_when_disabled_R8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> strobes.incAmt == '0);

  // Pure cycles are a subset of miss cycles
  assert_pure_cycle_in_miss_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incAmt[CNT_PURE_CYC] != '0 |-> strobes.incAmt[CNT_MISS_CYC] != '0);

endmodule

// File: rtl/memmon_dp.sv
`timescale 1ns/1ps
module memmon_dp
  import memmon_pkg::*;
#(
  parameter int CNT_W  = 48,
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData
);

  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'({CNT_W{1'b1}});

  logic [CNT_W-1:0] cntQ [NUM_CNT];
  logic [CNT_W-1:0] rdNext;

  for (genvar g = 0; g < NUM_CNT; g++) begin : genCnt
    logic [SUM_W-1:0] sumRaw;
    logic [CNT_W-1:0] cntNext;

    assign sumRaw  = SUM_W'(cntQ[g]) + SUM_W'(strobes.incAmt[g]);
    assign cntNext = (sumRaw > CNT_MAX) ? {CNT_W{1'b1}} : sumRaw[CNT_W-1:0];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              cntQ[g] <= '0;
      else if (strobes.clear) cntQ[g] <= '0;
      else                    cntQ[g] <= cntNext;
    end

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
      strobes.clear |=> cntQ[g] == '0);

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
      !strobes.clear |=> cntQ[g] >= $past(cntQ[g]));
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rdAddr == ADDR_W'(i)) rdNext = cntQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  assert_pure_le_miss_cyc_R5: assert property (@(posedge clk) disable iff (!rstN)
    cntQ[CNT_PURE_CYC] <= cntQ[CNT_MISS_CYC]);

  assert_pure_le_miss_R7: assert property (@(posedge clk) disable iff (!rstN)
    cntQ[CNT_PURE_MISS] <= cntQ[CNT_MISS]);

  assert_hit_le_active_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntQ[CNT_HIT_CYC] <= cntQ[CNT_ACTIVE] && cntQ[CNT_MISS_CYC] <= cntQ[CNT_ACTIVE]);

endmodule

// File: rtl/memmon_top.sv
`timescale 1ns/1ps
module memmon_top
  import memmon_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int ENTRIES = 8,
  parameter int HIT_W   = 4,
  localparam int ID_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              clear,
  input  logic              accessStart,
  input  logic [HIT_W-1:0]  hitActive,
  input  logic              allocValid,
  input  logic [ID_W-1:0]   allocId,
  input  logic              retireValid,
  input  logic [ID_W-1:0]   retireId,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData
);

  strobeT strobes;

  memmon_ctrl #(.ENTRIES(ENTRIES), .HIT_W(HIT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear),
    .accessStart(accessStart), .hitActive(hitActive),
    .allocValid(allocValid), .allocId(allocId),
    .retireValid(retireValid), .retireId(retireId),
    .strobes(strobes)
  );

  memmon_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: tb/tb_memmon_top.sv
`timescale 1ns/1ps
module tb_memmon_top;
  localparam int CNT_W   = 8;
  localparam int ENTRIES = 4;
  localparam int HIT_W   = 3;
  localparam int ID_W    = 2;
  localparam int CMAX    = 255;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, clear = 1'b0, accessStart = 1'b0;
  logic [HIT_W-1:0] hitActive = '0;
  logic allocValid = 1'b0, retireValid = 1'b0;
  logic [ID_W-1:0] allocId = '0, retireId = '0;
  logic [3:0] rdAddr = '0;
  logic [CNT_W-1:0] rdData;

  int checks = 0, fails = 0;
  int expCnt [9];
  bit mValid [ENTRIES];
  bit mPure  [ENTRIES];
  int unsigned lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  memmon_top #(.CNT_W(CNT_W), .ENTRIES(ENTRIES), .HIT_W(HIT_W)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .clear(clear),
    .accessStart(accessStart), .hitActive(hitActive),
    .allocValid(allocValid), .allocId(allocId),
    .retireValid(retireValid), .retireId(retireId),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic string reqOf(int k);
    case (k)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 8: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic int unsigned nextRand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic addSat(int k, int v);
    expCnt[k] = (expCnt[k] + v > CMAX) ? CMAX : expCnt[k] + v;
  endtask

  // One clock: drive at negedge, update model for the coming edge
  task automatic step(bit acc, int hit, bit aV, int aId, bit rV, int rId, bit en, bit clr);
    int occ;
    bit hitAny, missAny, pureNow, aOk, rOk;
    accessStart = acc; hitActive = HIT_W'(hit);
    allocValid = aV; allocId = ID_W'(aId);
    retireValid = rV; retireId = ID_W'(rId);
    enable = en; clear = clr;
    occ = 0;
    for (int i = 0; i < ENTRIES; i++) occ += int'(mValid[i]);
    hitAny = hit > 0; missAny = occ > 0; pureNow = missAny && !hitAny;
    rOk = rV && mValid[rId];
    aOk = aV && !mValid[aId];
    if (clr) begin
      for (int k = 0; k < 9; k++) expCnt[k] = 0;
    end else if (en) begin
      addSat(0, int'(acc));
      addSat(1, int'(hitAny || missAny));
      addSat(2, int'(hitAny));
      addSat(3, hit);
      addSat(4, int'(missAny));
      addSat(5, int'(pureNow));
      addSat(6, int'(rOk));
      addSat(7, int'(rOk && (mPure[rId] || pureNow)));
      addSat(8, occ);
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (clr) mPure[i] = 0;
      else if (aOk && aId == i) mPure[i] = 0;
      else if (rOk && rId == i) mPure[i] = 0;
      else if (en && pureNow && mValid[i]) mPure[i] = 1;
    end
    if (rOk) mValid[rId] = 0;
    if (aOk) mValid[aId] = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic readCheck(int addr, int exp, string tag);
    rdAddr = 4'(addr);
    idle();
    check($sformatf("%s addr %0d", tag, addr), int'(rdData), exp);
  endtask

  task automatic checkAll(string tag);
    for (int k = 0; k < 9; k++) readCheck(k, expCnt[k], {tag, "/", reqOf(k)});
    readCheck(12, 0, {tag, "/R11 unmapped"});
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 9; k++) expCnt[k] = 0;
    for (int i = 0; i < ENTRIES; i++) begin mValid[i] = 0; mPure[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    check("R11 rdData after reset", int'(rdData), 0);
    checkAll("R11 reset");

    // R1 R2 R3: accesses and hit concurrency
    step(1, 1, 0, 0, 0, 0, 1, 0);
    step(1, 3, 0, 0, 0, 0, 1, 0);
    step(0, 2, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(0, 7, 0, 0, 0, 0, 1, 0);
    checkAll("R3 hits");

    // R11: read shows the value held before the edge while counting
    rdAddr = 4'd0;
    step(1, 0, 0, 0, 0, 0, 1, 0);
    check("R11 latency", int'(rdData), expCnt[0] - 1);

    // R4 R5 R7: mixed hit/miss lifetimes
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 2, 1, 0, 0, 0, 1, 0);    // alloc 0
    step(0, 2, 0, 0, 0, 0, 1, 0);    // 0 outstanding with hit
    step(0, 1, 1, 1, 1, 0, 1, 0);    // retire 0 with hit: not pure; alloc 1
    step(0, 0, 0, 0, 0, 0, 1, 0);    // pure cycle for 1
    step(0, 4, 0, 0, 1, 1, 1, 0);    // retire 1: pure
    step(0, 1, 1, 2, 0, 0, 1, 0);    // alloc 2
    step(0, 0, 0, 0, 1, 2, 1, 0);    // retire 2, purity only in retire cycle
    checkAll("R7 pure tagging");

    // R6: bogus retire and busy allocate are ignored
    step(0, 1, 1, 3, 0, 0, 1, 0);
    step(0, 1, 1, 3, 1, 0, 1, 0);    // alloc busy 3, retire free 0
    step(0, 1, 0, 0, 1, 3, 1, 0);
    checkAll("R6 ignored events");

    // R8: traffic with enable low is tracked but not counted
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 3, 1, 0, 0, 0, 0, 0);
    step(1, 0, 1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    checkAll("R8 disabled");
    step(0, 0, 0, 0, 0, 0, 1, 0);    // two outstanding now counted
    step(0, 0, 0, 0, 1, 0, 1, 0);
    step(0, 0, 0, 0, 1, 1, 0, 0);
    checkAll("R8 resumed");

    // R9: clear drops a pure flag on an entry in flight
    step(0, 0, 1, 2, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);    // entry 2 pure
    step(1, 0, 0, 0, 0, 0, 1, 1);    // clear beats the count
    step(0, 2, 0, 0, 1, 2, 1, 0);    // retire with hit: not pure after clear
    checkAll("R9 clear");

    // R10: saturation
    step(0, 0, 0, 0, 0, 0, 0, 1);
    for (int c = 0; c < 300; c++) step(1, 7, 0, 0, 0, 0, 1, 0);
    checkAll("R10 saturate");

    // R2 sweep: pseudo-random overlapping traffic
    step(0, 0, 0, 0, 0, 0, 0, 1);
    for (int c = 0; c < 3000; c++) begin
      int unsigned r;
      r = nextRand();
      step(r[0], (r[3:1] > 4) ? 0 : int'(r[3:1]), r[4] & r[5], int'(r[7:6]),
           r[8] & r[9], int'(r[11:10]), r[15:12] != 0, r[23:16] == 8'd7);
      if (c % 250 == 249) checkAll("R2 sweep");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule